// File: doc/BRIEF.md
# Pipelined Pre-Adder Multiply-Add Unit

This unit forms a signed fixed-point result from four operands in one pass: a pre-adder combines `op_d` with `op_a`, the sum is multiplied by `op_b`, the product may be negated, and a final adder adds or subtracts `op_c`. Three run-time control bits choose the sign of each step. It is the arithmetic element from which three-multiplier complex-multiplier schedules are assembled: the shared cross term goes in one unit, and its result feeds the `op_c` port of the other two.

Five parameters each keep or remove one pipeline register: the operand input register, the register after the pre-adder, the register after the multiplier, the `op_c` input register and the shared output register. The operand path (`op_a`, `op_b`, `op_d`) passes through up to four registers. The `op_c` path passes through up to two. A schedule can therefore trade latency in cycles against combinational depth per stage. The final adder is always present, so a plain product is obtained by driving `op_c` with zero. A valid flag travels with the operand path.

Top module: `preadd_mac`

## Requirements
- R1: `out_p` equals Sm·((D ± A)·B) + Sc·C, taken modulo 2^48 as a 48-bit two's-complement value. `pre_sub`=1 selects D−A and 0 selects D+A. `prod_neg`=1 gives Sm=−1 and 0 gives Sm=+1. `post_sub`=1 gives Sc=−1 and 0 gives Sc=+1.
- R2: `op_a`, `op_b`, `op_d`, `pre_sub` and `prod_neg` reach `out_p` after LA = KEEP_IN+KEEP_PRE+KEEP_MUL+KEEP_OUT clock cycles.
- R3: `op_c` and `post_sub` reach `out_p` after LC = KEEP_C+KEEP_OUT clock cycles, so one result may combine operands taken from different input cycles.
- R4: All operands are signed two's complement (A and D 25 bits, B 18 bits, C 48 bits). The pre-adder sum is kept at 26 bits and the product at 44 bits, and both are sign-extended without loss.
- R5: `out_valid` equals `in_valid` delayed by LA cycles, and reads 0 for the first LA cycles after reset.
- R6: When the C term of a result is zero, `out_p` equals the signed, optionally negated product alone.
- R7: An active-low asynchronous reset clears every kept register. While reset is low and the output register is kept, `out_p`=0 and `out_valid`=0.
- R8: With every register removed, the unit is purely combinational: `out_p` and `out_valid` follow the inputs within the same cycle.
- R9: Extreme operands (A=D=−2^24, B=−2^17; A=D=2^24−1, B=2^17−1) produce exact products up to 2^42 in magnitude.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Marks the operand set as valid |
| pre_sub | input | 1 | 1: pre-adder forms D−A; 0: D+A |
| prod_neg | input | 1 | 1: product is negated |
| post_sub | input | 1 | 1: C is subtracted; 0: C is added |
| op_a | input | 25 | Signed pre-adder operand A |
| op_b | input | 18 | Signed multiplier operand B |
| op_c | input | 48 | Signed post-adder operand C |
| op_d | input | 25 | Signed pre-adder operand D |
| out_valid | output | 1 | in_valid delayed by the operand-path latency |
| out_p | output | 48 | Signed result |

## Verification
The hardest case to bring about is a result whose product term and C term come from different input cycles. This happens whenever the operand path keeps more registers than the C path, and it shows up only while operands change every cycle. The bench builds all 32 keep/bypass variants side by side and streams a back-to-back vector table through them. For each variant it forms the expected result from the product of the vector LA cycles back and the C term of the vector LC cycles back, so a stage that is mis-timed on either path shows up as a wrong sum.

// File: rtl/preadd_mac_pkg.sv
package preadd_mac_pkg;

    // Sign controls that travel with the operand path.
    typedef struct packed {
        logic pre_sub;
        logic prod_neg;
    } sign_ctl_t;

    // Number of kept registers on a path.
    function automatic int pipe_depth(bit k0, bit k1, bit k2, bit k3);
        return int'(k0) + int'(k1) + int'(k2) + int'(k3);
    endfunction

endpackage

// File: rtl/pma_stage.sv
// One optional pipeline register: kept or replaced by a wire.
module pma_stage #(
    parameter int W    = 8,
    parameter bit KEEP = 1'b1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    generate
        if (KEEP) begin : g_reg
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) q <= '0;
                else        q <= d;
            end
        end else begin : g_wire
            logic unused_clk_rst;
            assign unused_clk_rst = clk ^ rst_n;
            assign q = d;
        end
    endgenerate
endmodule

// File: rtl/pma_preadd.sv
// Pre-adder: D plus or minus A, one bit wider than the operands.
module pma_preadd #(
    parameter int AW = 25
) (
    input  logic signed [AW-1:0] a,
    input  logic signed [AW-1:0] d,
    input  logic                 sub,
    output logic signed [AW:0]   s
);
    logic signed [AW:0] a_x;
    logic signed [AW:0] d_x;

    assign a_x = (AW+1)'(a);
    assign d_x = (AW+1)'(d);
    assign s   = sub ? (d_x - a_x) : (d_x + a_x);
endmodule

// File: rtl/pma_mul.sv
// Signed multiplier with optional negation, sign-extended to the result width.
module pma_mul #(
    parameter int SW = 26,
    parameter int BW = 18,
    parameter int PW = 48
) (
    input  logic signed [SW-1:0] s,
    input  logic signed [BW-1:0] b,
    input  logic                 neg,
    output logic signed [PW-1:0] m
);
    localparam int MW = SW + BW;

    logic signed [MW-1:0] prod;
    logic signed [PW-1:0] prod_x;

    assign prod   = s * b;
    assign prod_x = PW'(prod);
    assign m      = neg ? -prod_x : prod_x;
endmodule

// File: rtl/preadd_mac.sv
module preadd_mac
    import preadd_mac_pkg::*;
#(
    parameter int AW       = 25,
    parameter int BW       = 18,
    parameter int CW       = 48,
    parameter bit KEEP_IN  = 1'b1,
    parameter bit KEEP_PRE = 1'b1,
    parameter bit KEEP_MUL = 1'b1,
    parameter bit KEEP_C   = 1'b1,
    parameter bit KEEP_OUT = 1'b1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  logic                 pre_sub,
    input  logic                 prod_neg,
    input  logic                 post_sub,
    input  logic signed [AW-1:0] op_a,
    input  logic signed [BW-1:0] op_b,
    input  logic signed [CW-1:0] op_c,
    input  logic signed [AW-1:0] op_d,
    output logic                 out_valid,
    output logic signed [CW-1:0] out_p
);
    localparam int SW  = AW + 1;
    localparam int PW  = CW;
    localparam int S1W = 1 + $bits(sign_ctl_t) + 2 * AW + BW;
    localparam int S2W = 2 + SW + BW;
    localparam int S3W = 1 + PW;
    localparam int SCW = 1 + CW;
    localparam int S4W = 1 + PW;

    // Stage 1: operand input register
    sign_ctl_t          in_ctl;
    sign_ctl_t          s1_ctl;
    logic [S1W-1:0]     s1_d, s1_q;
    logic               s1_v;
    logic signed [AW-1:0] s1_a, s1_d_op;
    logic signed [BW-1:0] s1_b;

    assign in_ctl = '{pre_sub: pre_sub, prod_neg: prod_neg};
    assign s1_d   = {in_valid, in_ctl, op_a, op_d, op_b};

    pma_stage #(.W(S1W), .KEEP(KEEP_IN)) u_st_in (
        .clk(clk), .rst_n(rst_n), .d(s1_d), .q(s1_q)
    );
    assign {s1_v, s1_ctl, s1_a, s1_d_op, s1_b} = s1_q;

    // Pre-adder and stage 2
    logic signed [SW-1:0] pre_sum;

    pma_preadd #(.AW(AW)) u_pre (
        .a(s1_a), .d(s1_d_op), .sub(s1_ctl.pre_sub), .s(pre_sum)
    );

    logic [S2W-1:0]       s2_d, s2_q;
    logic                 s2_v, s2_neg;
    logic signed [SW-1:0] s2_sum;
    logic signed [BW-1:0] s2_b;

    assign s2_d = {s1_v, s1_ctl.prod_neg, pre_sum, s1_b};

    pma_stage #(.W(S2W), .KEEP(KEEP_PRE)) u_st_pre (
        .clk(clk), .rst_n(rst_n), .d(s2_d), .q(s2_q)
    );
    assign {s2_v, s2_neg, s2_sum, s2_b} = s2_q;

    // Multiplier and stage 3
    logic signed [PW-1:0] mul_res;

    pma_mul #(.SW(SW), .BW(BW), .PW(PW)) u_mul (
        .s(s2_sum), .b(s2_b), .neg(s2_neg), .m(mul_res)
    );

    logic [S3W-1:0]       s3_q;
    logic                 s3_v;
    logic signed [PW-1:0] s3_m;

    pma_stage #(.W(S3W), .KEEP(KEEP_MUL)) u_st_mul (
        .clk(clk), .rst_n(rst_n), .d({s2_v, mul_res}), .q(s3_q)
    );
    assign {s3_v, s3_m} = s3_q;

    // C input register, carrying its own sign control
    logic [SCW-1:0]       sc_q;
    logic                 sc_sub;
    logic signed [CW-1:0] sc_c;

    pma_stage #(.W(SCW), .KEEP(KEEP_C)) u_st_c (
        .clk(clk), .rst_n(rst_n), .d({post_sub, op_c}), .q(sc_q)
    );
    assign {sc_sub, sc_c} = sc_q;

    // Final adder (always present) and output register
    logic signed [PW-1:0] fin_sum;
    logic [S4W-1:0]       s4_q;

    assign fin_sum = s3_m + (sc_sub ? -sc_c : sc_c);

    pma_stage #(.W(S4W), .KEEP(KEEP_OUT)) u_st_out (
        .clk(clk), .rst_n(rst_n), .d({s3_v, fin_sum}), .q(s4_q)
    );
    assign {out_valid, out_p} = s4_q;

endmodule

// File: rtl/preadd_mac_chk.sv
module preadd_mac_chk
    import preadd_mac_pkg::*;
#(
    parameter int AW       = 25,
    parameter int BW       = 18,
    parameter int CW       = 48,
    parameter bit KEEP_IN  = 1'b1,
    parameter bit KEEP_PRE = 1'b1,
    parameter bit KEEP_MUL = 1'b1,
    parameter bit KEEP_C   = 1'b1,
    parameter bit KEEP_OUT = 1'b1
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 in_valid,
    input logic                 pre_sub,
    input logic                 prod_neg,
    input logic                 post_sub,
    input logic signed [AW-1:0] op_a,
    input logic signed [BW-1:0] op_b,
    input logic signed [CW-1:0] op_c,
    input logic signed [AW-1:0] op_d,
    input logic                 out_valid,
    input logic signed [CW-1:0] out_p
);
    localparam int LA = pipe_depth(KEEP_IN, KEEP_PRE, KEEP_MUL, KEEP_OUT);
    localparam int LC = pipe_depth(KEEP_C, KEEP_OUT, 1'b0, 1'b0);
    localparam int HD = 4;

    // Reference terms formed from the ports in the cycle they are presented
    logic signed [AW:0]    ref_pre;
    logic signed [AW+BW:0] ref_mul;
    logic signed [CW-1:0]  ref_ext;
    logic signed [CW-1:0]  a_now, c_now;

    assign ref_pre = pre_sub ? ((AW+1)'(op_d) - (AW+1)'(op_a))
                             : ((AW+1)'(op_d) + (AW+1)'(op_a));
    assign ref_mul = ref_pre * op_b;
    assign ref_ext = CW'(ref_mul);
    assign a_now   = prod_neg ? -ref_ext : ref_ext;
    assign c_now   = post_sub ? -op_c : op_c;

    logic signed [CW-1:0] a_dly [HD];
    logic signed [CW-1:0] c_dly [HD];
    logic                 v_dly [HD];
    logic [2:0]           cyc;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cyc <= '0;
            for (int i = 0; i < HD; i++) begin
                a_dly[i] <= '0;
                c_dly[i] <= '0;
                v_dly[i] <= 1'b0;
            end
        end else begin
            if (cyc != 3'd7) cyc <= cyc + 3'd1;
            a_dly[0] <= a_now;
            c_dly[0] <= c_now;
            v_dly[0] <= in_valid;
            for (int i = 1; i < HD; i++) begin
                a_dly[i] <= a_dly[i-1];
                c_dly[i] <= c_dly[i-1];
                v_dly[i] <= v_dly[i-1];
            end
        end
    end

    logic signed [CW-1:0] a_tap, c_tap;
    logic                 v_tap;

    generate
        if (LA == 0) begin : g_a0
            assign a_tap = a_now;
            assign v_tap = in_valid;
        end else begin : g_an
            assign a_tap = a_dly[LA-1];
            assign v_tap = v_dly[LA-1];
        end
        if (LC == 0) begin : g_c0
            assign c_tap = c_now;
        end else begin : g_cn
            assign c_tap = c_dly[LC-1];
        end
    endgenerate

    // R1, R2, R3: result combines the operand term LA cycles back and the C term LC cycles back
    assert_result_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(cyc) >= LA && int'(cyc) >= LC) |-> (out_p == a_tap + c_tap));

    // R5: valid follows in_valid with the operand-path latency
    assert_valid_lat_R5: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid == v_tap);

    // R6: zero C term leaves the product alone
    assert_product_only_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(cyc) >= LA && int'(cyc) >= LC && c_tap == '0) |-> (out_p == a_tap));

    // R7: kept output register reads zero while reset is held
    always @(negedge clk) begin
        if (!rst_n && KEEP_OUT) begin
            assert_reset_clear_R7: assert (out_p == '0 && out_valid == 1'b0);
        end
    end

endmodule

bind preadd_mac preadd_mac_chk #(
    .AW(AW), .BW(BW), .CW(CW),
    .KEEP_IN(KEEP_IN), .KEEP_PRE(KEEP_PRE), .KEEP_MUL(KEEP_MUL),
    .KEEP_C(KEEP_C), .KEEP_OUT(KEEP_OUT)
) u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .pre_sub(pre_sub), .prod_neg(prod_neg), .post_sub(post_sub),
    .op_a(op_a), .op_b(op_b), .op_c(op_c), .op_d(op_d),
    .out_valid(out_valid), .out_p(out_p)
);

// File: tb/tb_preadd_mac.sv
module tb_preadd_mac;

    localparam int NV = 16;
    localparam int NVAR = 32;
    localparam int STEPS = 2 * NV + 4;

    typedef struct packed {
        logic               vin;
        logic               ps;
        logic               pn;
        logic               cs;
        logic signed [24:0] a;
        logic signed [24:0] d;
        logic signed [17:0] b;
        logic signed [47:0] c;
        logic signed [47:0] em;   // expected signed product term, Sm*((D±A)*B)
    } vec_t;

    // Stimulus and expected product term per vector
    localparam vec_t TBL [NV] = '{
        '{1'b1, 1'b0, 1'b0, 1'b0, 25'sd3,    25'sd5,    18'sd7,     48'sd100,  48'sd56},
        '{1'b1, 1'b1, 1'b0, 1'b1, 25'sd3,    25'sd5,    18'sd7,     48'sd100,  48'sd14},
        '{1'b0, 1'b1, 1'b0, 1'b0, 25'sd10,   25'sd4,    -18'sd3,    48'sd0,    48'sd18},
        '{1'b1, 1'b0, 1'b1, 1'b0, 25'sd10,   25'sd4,    -18'sd3,    -48'sd5,   48'sd42},
        '{1'b1, 1'b0, 1'b0, 1'b1, -25'sd100, -25'sd200, 18'sd50,    48'sd0,    -48'sd15000},
        '{1'b0, 1'b1, 1'b1, 1'b1, 25'sd1,    25'sd0,    18'sd1,     48'sd1,    48'sd1},
        '{1'b1, 1'b0, 1'b0, 1'b0, 25'sd0,    25'sd0,    18'sd12345, -48'sd1,   48'sd0},
        // R9 extremes: sign-extended sums and products (R4)
        '{1'b1, 1'b0, 1'b0, 1'b0, 25'h1000000, 25'h1000000, 18'h20000, 48'sd0, 48'sd4398046511104},
        '{1'b1, 1'b1, 1'b0, 1'b0, 25'h0FFFFFF, 25'h1000000, 18'h20000, 48'sd0, 48'sd4398046380032},
        '{1'b0, 1'b0, 1'b1, 1'b0, 25'h0FFFFFF, 25'h0FFFFFF, 18'h1FFFF, 48'sd0, -48'sd4398012694530},
        '{1'b1, 1'b1, 1'b0, 1'b0, 25'sd7,    25'sd7,    -18'sd1,    48'h7FFFFFFFFFFF, 48'sd0},
        '{1'b1, 1'b0, 1'b0, 1'b1, 25'sd1,    25'sd1,    18'sd1,     48'h800000000000, 48'sd2},
        '{1'b1, 1'b1, 1'b1, 1'b1, -25'sd5,   25'sd9,    -18'sd8,    48'sd1000, 48'sd112},
        '{1'b0, 1'b0, 1'b0, 1'b1, 25'sd123,  -25'sd7,   18'sd1000,  -48'sd3000, 48'sd116000},
        '{1'b1, 1'b0, 1'b1, 1'b0, 25'sd0,    -25'sd1,   -18'sd1,    48'sd0,    -48'sd1},
        '{1'b1, 1'b0, 1'b0, 1'b0, 25'sd65535, 25'sd65535, 18'sd65535, -48'sd8589672450, 48'sd8589672450}
    };

    logic clk = 1'b0;
    logic rst_n;
    logic in_valid, pre_sub, prod_neg, post_sub;
    logic signed [24:0] op_a, op_d;
    logic signed [17:0] op_b;
    logic signed [47:0] op_c;

    logic signed [47:0] p_all [NVAR];
    logic               v_all [NVAR];

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    // Every keep/bypass combination: bit0 IN, bit1 PRE, bit2 MUL, bit3 C, bit4 OUT
    generate
        for (genvar g = 0; g < NVAR; g++) begin : g_var
            preadd_mac #(
                .KEEP_IN (((g >> 0) & 1) == 1),
                .KEEP_PRE(((g >> 1) & 1) == 1),
                .KEEP_MUL(((g >> 2) & 1) == 1),
                .KEEP_C  (((g >> 3) & 1) == 1),
                .KEEP_OUT(((g >> 4) & 1) == 1)
            ) dut (
                .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
                .pre_sub(pre_sub), .prod_neg(prod_neg), .post_sub(post_sub),
                .op_a(op_a), .op_b(op_b), .op_c(op_c), .op_d(op_d),
                .out_valid(v_all[g]), .out_p(p_all[g])
            );
        end
    endgenerate

    function automatic int lat_a(int v);
        return (v & 1) + ((v >> 1) & 1) + ((v >> 2) & 1) + ((v >> 4) & 1);
    endfunction

    function automatic int lat_c(int v);
        return ((v >> 3) & 1) + ((v >> 4) & 1);
    endfunction

    function automatic logic signed [47:0] cterm(vec_t x);
        return x.cs ? -x.c : x.c;
    endfunction

    task automatic apply(vec_t x);
        in_valid = x.vin;
        pre_sub  = x.ps;
        prod_neg = x.pn;
        post_sub = x.cs;
        op_a     = x.a;
        op_b     = x.b;
        op_c     = x.c;
        op_d     = x.d;
    endtask

    task automatic check_p(string tag, int v, logic signed [47:0] act, logic signed [47:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s variant %0d: p=%0d expected %0d", tag, v, act, exp);
        end
    endtask

    task automatic check_v(string tag, int v, logic act, logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s variant %0d: valid=%0b expected %0b", tag, v, act, exp);
        end
    endtask

    // Streaming check for step k across all variants (R1, R2, R3, R5)
    task automatic check_step(int k);
        for (int v = 0; v < NVAR; v++) begin
            int la = lat_a(v);
            int lc = lat_c(v);
            logic exp_v = (k >= la) ? TBL[(k - la) % NV].vin : 1'b0;
            check_v($sformatf("R5 step %0d", k), v, v_all[v], exp_v);
            if (k >= la && k >= lc) begin
                int ia = (k - la) % NV;
                logic signed [47:0] ct = cterm(TBL[(k - lc) % NV]);
                string tag;
                if (ia >= 7 && ia <= 9)  tag = "R9 R4";
                else if (ct == 48'sd0)   tag = "R6";
                else                     tag = "R1";
                check_p($sformatf("%s R2 R3 step %0d", tag, k), v, p_all[v], TBL[ia].em + ct);
            end
        end
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        rst_n    = 1'b0;
        in_valid = 1'b0; pre_sub = 1'b0; prod_neg = 1'b0; post_sub = 1'b0;
        op_a = '0; op_b = '0; op_c = '0; op_d = '0;

        // R7: state while reset is held with idle inputs
        repeat (3) @(negedge clk);
        #5;
        for (int v = 0; v < NVAR; v++) begin
            check_p("R7 reset", v, p_all[v], 48'sd0);
            check_v("R7 reset", v, v_all[v], 1'b0);
        end

        // Release and stream the table back to back
        @(negedge clk);
        rst_n = 1'b1;
        for (int k = 0; k < STEPS; k++) begin
            apply(TBL[k % NV]);
            #5;
            check_step(k);
            @(negedge clk);
        end

        // R8: all registers removed -> same-cycle response, no clock edge between
        apply(TBL[1]);
        #1;
        check_p("R8 comb", 0, p_all[0], TBL[1].em + cterm(TBL[1]));
        check_v("R8 comb", 0, v_all[0], TBL[1].vin);
        apply(TBL[3]);
        #1;
        check_p("R8 comb", 0, p_all[0], TBL[3].em + cterm(TBL[3]));
        check_v("R8 comb", 0, v_all[0], TBL[3].vin);
        apply(TBL[2]);
        #1;
        check_v("R8 comb", 0, v_all[0], TBL[2].vin);

        // R7: reset asserted mid-stream clears kept output registers at once
        apply(TBL[15]);
        repeat (5) @(negedge clk);
        #2;
        rst_n = 1'b0;
        #1;
        for (int v = 16; v < NVAR; v++) begin
            check_p("R7 mid-run", v, p_all[v], 48'sd0);
            check_v("R7 mid-run", v, v_all[v], 1'b0);
        end
        @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule